// File: doc/BRIEF.md
# BCD Calendar Counter with Drift Compensation

This block keeps wall-clock time in packed BCD: seconds, minutes, hours, day of month, month, a two-byte year and a weekday. A one-cycle `tick` strobe, one per cycle of the 32.768 kHz oscillator, drives a prescaler. Every `TICKS_PER_SEC` ticks the prescaler issues a one-second strobe, and the calendar advances on that strobe. The calendar handles month lengths and leap years.

Software uses a byte-wide write port and a combinational read port. It starts and stops the counter through a control register and confirms that the change has taken effect by polling a status bit. It can freeze a snapshot of the time and choose whether reads return the snapshot or the live counters.

Three compensation registers adjust the length of the seconds inside minute 59. The hourly register applies in every hour. The daily register applies only in hour 23. The monthly register applies only in hour 23 of the month's last day. Each register adds or removes oscillator cycles, one cycle per second, so that slow or fast crystals can be trimmed.

Top module: `rtc_calendar`

## Requirements
- R1: Register map. Addresses 0 to 7 hold the time fields: seconds, minutes, hours, day, month, year-low, year-high and weekday. Their widths are 7, 7, 6, 6, 5, 8, 8 and 3 bits, and unused upper bits read as zero. After reset the time is 00:00:00, day 01, month 01, year 0000, weekday 0, and the status register reads 0.
- R2: Control register, address 8, bit 0 requests running. Status register, address 9, bit 0 takes the value of control bit 0 on the next tick. The calendar advances only while status bit 0 is 1.
- R3: A write to addresses 0 to 7 while status bit 0 is 1 is ignored. While status bit 0 is 0, such a write loads the field.
- R4: Without compensation, a second lasts exactly `TICKS_PER_SEC` ticks, counted from the first tick after status bit 0 becomes 1.
- R5: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the day. The weekday steps on each day carry and wraps from 6 to 0.
- R6: Months 4, 6, 9 and 11 have 30 days and the other months have 31. February has 29 days when the year is divisible by 4, which depends only on year-low, and 28 days otherwise.
- R7: Month wraps from 12 to 01 and increments year-low. Year-low wraps from 99 to 00 and increments year-high.
- R8: Writing control bit 6 as 1 copies the live time into a snapshot. While control bit 7 is 1, reads of addresses 0 to 7 return the snapshot. Control reads back as written, with bit 6 always reading 0.
- R9: Compensation registers sit at address 10 (hour), 11 (day) and 12 (month). Bit 7 set means add, and each affected second is one tick shorter. Bit 7 clear means subtract, and each affected second is one tick longer. The low 7 bits L give a magnitude of L+1, except that L=1 means none. The adjustment starts with second :59:00 and uses one tick per second.
- R10: The hourly amount applies in every hour. The daily amount applies only when the hour is 23. The monthly amount applies only in hour 23 of the month's last day. The amounts that apply are summed with their signs.
- R11: When control bit 2 is 0, no second is shortened or lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe per oscillator cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational |

## Verification
The most involved cycle is the second strobe that ends :58:59 in hour 23. On that one strobe, the minute rolls over and the hourly, daily and monthly amounts are loaded together as a signed sum. The bench reaches this cycle by loading 23:58:59 on ordinary days and on last days, with amounts that cancel or add. It judges the result by counting ticks until :59:00 turns into :59:01.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the BCD calendar.
// Assumes BCD fields hold legal digits; illegal loads advance by plain arithmetic.
package rtc_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CMP_H = 4'd10;
    localparam logic [ADDR_W-1:0] A_CMP_D = 4'd11;
    localparam logic [ADDR_W-1:0] A_CMP_M = 4'd12;

    typedef struct packed {
        logic [7:0] yh;
        logic [7:0] yl;
        logic [4:0] mon;
        logic [5:0] day;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
        logic [2:0] wday;
    } rtc_time_t;

    // Increment a two-digit BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day of a month in BCD; leap test uses (2*tens + ones) mod 4.
    function automatic logic [5:0] month_days(input logic [4:0] mon, input logic [7:0] yl);
        logic [1:0] lsum;
        lsum = {yl[4], 1'b0} + yl[1:0];
        case (mon)
            5'h02:                      return (lsum == 2'd0) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // Signed tick adjustment from a compensation register; positive shortens.
    function automatic logic signed [9:0] comp_amount(input logic [7:0] raw);
        logic signed [9:0] mag;
        mag = (raw[6:0] == 7'd1) ? 10'sd0 : signed'({3'b000, raw[6:0]}) + 10'sd1;
        return raw[7] ? mag : -mag;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides oscillator ticks into one-second strobes.
// Assumes TPS >= 3; shorten/lengthen move the period by one tick.
module rtc_prescaler #(
    parameter int TPS   = 32768,
    parameter int CNT_W = $clog2(TPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             shorten,
    input  logic             lengthen,
    output logic             sec_stb,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] limit;

    // Last count of the current second, moved by compensation.
    always_comb begin
        if (shorten)       limit = CNT_W'(TPS - 2);
        else if (lengthen) limit = CNT_W'(TPS);
        else               limit = CNT_W'(TPS - 1);
    end

    assign sec_stb = run && tick && (cnt >= limit);

    // Tick counter, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_cal_core.sv
// BCD calendar registers with rollover chain and field loading.
// Assumes the caller gates field writes (only while stopped).
module rtc_cal_core
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_stb,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output rtc_time_t  live,
    output logic       last_day
);
    rtc_time_t nxt;

    assign last_day = (live.day == month_days(live.mon, live.yl));

    // Next time after one second, carrying through every field.
    always_comb begin
        nxt     = live;
        nxt.sec = 7'(bcd_inc({1'b0, live.sec}));
        if (live.sec == 7'h59) begin
            nxt.sec = '0;
            nxt.min = 7'(bcd_inc({1'b0, live.min}));
            if (live.min == 7'h59) begin
                nxt.min  = '0;
                nxt.hour = 6'(bcd_inc({2'b0, live.hour}));
                if (live.hour == 6'h23) begin
                    nxt.hour = '0;
                    nxt.wday = (live.wday == 3'd6) ? 3'd0 : live.wday + 3'd1;
                    nxt.day  = 6'(bcd_inc({2'b0, live.day}));
                    if (last_day) begin
                        nxt.day = 6'h01;
                        nxt.mon = 5'(bcd_inc({3'b0, live.mon}));
                        if (live.mon == 5'h12) begin
                            nxt.mon = 5'h01;
                            nxt.yl  = bcd_inc(live.yl);
                            if (live.yl == 8'h99) begin
                                nxt.yl = '0;
                                nxt.yh = (live.yh == 8'h99) ? 8'h00 : bcd_inc(live.yh);
                            end
                        end
                    end
                end
            end
        end
    end

    // Field load or one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live     <= '0;
            live.day <= 6'h01;
            live.mon <= 5'h01;
        end else if (wr_en) begin
            case (wr_idx)
                3'd0: live.sec  <= wr_data[6:0];
                3'd1: live.min  <= wr_data[6:0];
                3'd2: live.hour <= wr_data[5:0];
                3'd3: live.day  <= wr_data[5:0];
                3'd4: live.mon  <= wr_data[4:0];
                3'd5: live.yl   <= wr_data;
                3'd6: live.yh   <= wr_data;
                default: live.wday <= wr_data[2:0];
            endcase
        end else if (sec_stb) begin
            live <= nxt;
        end
    end
endmodule

// File: rtl/rtc_comp.sv
// Loads the summed compensation at the start of minute 59 and spends it one tick per second.
// Assumes the amounts are read on the strobe that ends :58:59.
module rtc_comp
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_stb,
    input  logic       en,
    input  logic [6:0] min,
    input  logic [6:0] sec,
    input  logic [5:0] hour,
    input  logic       last_day,
    input  logic [7:0] cmp_h,
    input  logic [7:0] cmp_d,
    input  logic [7:0] cmp_m,
    output logic       shorten,
    output logic       lengthen
);
    logic signed [9:0] rem;
    logic signed [9:0] net;
    logic              last_hr;

    assign last_hr = (hour == 6'h23);

    // Signed sum of the levels that apply in this hour.
    always_comb begin
        net = comp_amount(cmp_h);
        if (last_hr)             net = net + comp_amount(cmp_d);
        if (last_hr && last_day) net = net + comp_amount(cmp_m);
    end

    // Remaining ticks to apply in the final minute.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) rem <= '0;
        else if (sec_stb) begin
            if (min == 7'h58 && sec == 7'h59)      rem <= net;
            else if (min == 7'h59 && sec == 7'h59) rem <= '0;
            else if (rem > 0)                      rem <= rem - 10'sd1;
            else if (rem < 0)                      rem <= rem + 10'sd1;
        end
    end

    assign shorten  = en && (rem > 0);
    assign lengthen = en && (rem < 0);
endmodule

// File: rtl/rtc_calendar.sv
// Top: register file, run handshake, snapshot and read mux around the calendar.
// Assumes tick is a one-cycle strobe synchronous to clk.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC + 1);

    logic [7:0]       ctrl_q;
    logic             run_q;
    logic [7:0]       cmp_h, cmp_d, cmp_m;
    rtc_time_t        live, shadow, sel;
    logic             last_day, sec_stb, shorten, lengthen;
    logic [CNT_W-1:0] pre_cnt;
    logic             wr_ctrl, wr_time;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_time = wr_en && (wr_addr[3] == 1'b0) && !run_q;

    // Control register; bit 6 is a strobe and is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data & 8'hBF;
    end

    // Running status follows the start request on the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= 1'b0;
        else if (tick) run_q <= ctrl_q[0];
    end

    // Compensation registers, reset to "none".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_h <= 8'h01;
            cmp_d <= 8'h01;
            cmp_m <= 8'h01;
        end else if (wr_en) begin
            if (wr_addr == A_CMP_H) cmp_h <= wr_data;
            if (wr_addr == A_CMP_D) cmp_d <= wr_data;
            if (wr_addr == A_CMP_M) cmp_m <= wr_data;
        end
    end

    // Frozen copy of the live time.
    always_ff @(posedge clk) begin
        if (!rst_n)                    shadow <= '0;
        else if (wr_ctrl && wr_data[6]) shadow <= live;
    end

    rtc_prescaler #(.TPS(TICKS_PER_SEC), .CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q),
        .shorten(shorten), .lengthen(lengthen), .sec_stb(sec_stb), .cnt(pre_cnt)
    );

    rtc_cal_core u_core (
        .clk(clk), .rst_n(rst_n), .sec_stb(sec_stb), .wr_en(wr_time),
        .wr_idx(wr_addr[2:0]), .wr_data(wr_data), .live(live), .last_day(last_day)
    );

    rtc_comp u_comp (
        .clk(clk), .rst_n(rst_n), .sec_stb(sec_stb), .en(ctrl_q[2]),
        .min(live.min), .sec(live.sec), .hour(live.hour), .last_day(last_day),
        .cmp_h(cmp_h), .cmp_d(cmp_d), .cmp_m(cmp_m),
        .shorten(shorten), .lengthen(lengthen)
    );

    assign sel = ctrl_q[7] ? shadow : live;

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            4'd0:    rd_data = {1'b0, sel.sec};
            4'd1:    rd_data = {1'b0, sel.min};
            4'd2:    rd_data = {2'b0, sel.hour};
            4'd3:    rd_data = {2'b0, sel.day};
            4'd4:    rd_data = {3'b0, sel.mon};
            4'd5:    rd_data = sel.yl;
            4'd6:    rd_data = sel.yh;
            4'd7:    rd_data = {5'b0, sel.wday};
            A_CTRL:  rd_data = ctrl_q;
            A_STAT:  rd_data = {7'b0, run_q};
            A_CMP_H: rd_data = cmp_h;
            A_CMP_D: rd_data = cmp_d;
            A_CMP_M: rd_data = cmp_m;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
// Temporal checks on the calendar, attached by bind.
module rtc_calendar_chk
    import rtc_pkg::*;
#(
    parameter int TPS   = 32768,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run_q,
    input logic             sec_stb,
    input rtc_time_t        live,
    input logic [CNT_W-1:0] pre_cnt
);
    // R2
    run_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(run_q));

    // R3
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !sec_stb) |=> $stable(live));

    // R5
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_stb && live.sec == 7'h59) |=> (live.sec == 7'h00));

    // R7
    new_year_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_stb && live.mon == 5'h12 && live.day == 6'h31 && live.hour == 6'h23
         && live.min == 7'h59 && live.sec == 7'h59) |=> (live.mon == 5'h01));

    // R9
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= CNT_W'(TPS));
endmodule

bind rtc_calendar rtc_calendar_chk #(.TPS(TICKS_PER_SEC), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_q(run_q),
    .sec_stb(sec_stb), .live(live), .pre_cnt(pre_cnt)
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
    localparam int TPS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] adr_q[$];

    always #2 clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: pops expected items and compares away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            logic [3:0] a;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = adr_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, a, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
        end
    endtask

    // Driver: set the read address and push the expected item.
    task automatic chk(input logic [3:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(t); adr_q.push_back(a);
        wait (exp_q.size() == 0);
    endtask

    task automatic stop_clock();
        wr(4'd8, 8'h00);
        ticks(1);
    endtask

    task automatic load_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                             input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] yl, input logic [7:0] yh, input logic [7:0] wd);
        wr(4'd0, s);  wr(4'd1, mi); wr(4'd2, h);  wr(4'd3, d);
        wr(4'd4, mo); wr(4'd5, yl); wr(4'd6, yh); wr(4'd7, wd);
    endtask

    // Roll from 23:59:59 across one second and check the date.
    task automatic roll_day(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] yl,
                            input logic [7:0] yh, input logic [7:0] ed, input logic [7:0] emo,
                            input logic [7:0] eyl, input logic [7:0] eyh, input string t);
        stop_clock();
        load_time(8'h23, 8'h59, 8'h59, d, mo, yl, yh, 8'h06);
        wr(4'd8, 8'h01);
        ticks(1 + TPS);
        chk(4'd3, ed, t);  chk(4'd4, emo, t);
        chk(4'd5, eyl, t); chk(4'd6, eyh, t);
    endtask

    // Reach :59:00 with the given compensation, then measure that second.
    task automatic comp_case(input logic [7:0] h, input logic [7:0] d, input logic [7:0] ch,
                             input logic [7:0] cd, input logic [7:0] cm, input logic [7:0] ctl,
                             input int len, input string t);
        stop_clock();
        load_time(h, 8'h58, 8'h59, d, 8'h03, 8'h23, 8'h20, 8'h00);
        wr(4'd10, ch); wr(4'd11, cd); wr(4'd12, cm);
        wr(4'd8, ctl);
        ticks(1 + TPS);
        ticks(len - 1);
        chk(4'd0, 8'h00, t);
        ticks(1);
        chk(4'd0, 8'h01, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        chk(4'd0, 8'h00, "R1 sec"); chk(4'd1, 8'h00, "R1 min"); chk(4'd2, 8'h00, "R1 hour");
        chk(4'd3, 8'h01, "R1 day"); chk(4'd4, 8'h01, "R1 mon"); chk(4'd5, 8'h00, "R1 yl");
        chk(4'd7, 8'h00, "R1 wday"); chk(4'd9, 8'h00, "R1 status");

        // R1, R3: load while stopped, upper bits masked
        load_time(8'h12, 8'h34, 8'hD6, 8'h15, 8'h06, 8'h23, 8'h20, 8'h02);
        chk(4'd0, 8'h56, "R1 sec masked"); chk(4'd2, 8'h12, "R3 load hour");

        // R2: status follows on the next tick
        wr(4'd8, 8'h01);
        chk(4'd9, 8'h00, "R2 status before tick");
        ticks(1);
        chk(4'd9, 8'h01, "R2 status after tick");

        // R3: write ignored while running
        wr(4'd0, 8'h11);
        chk(4'd0, 8'h56, "R3 ignored while running");

        // R4: second length
        ticks(TPS - 1);
        chk(4'd0, 8'h56, "R4 before boundary");
        ticks(1);
        chk(4'd0, 8'h57, "R4 at boundary");

        // R8: snapshot and read select
        wr(4'd8, 8'h41);
        ticks(TPS);
        chk(4'd0, 8'h58, "R8 live");
        wr(4'd8, 8'h81);
        chk(4'd8, 8'h81, "R8 ctrl readback");
        chk(4'd0, 8'h57, "R8 shadow");
        wr(4'd8, 8'h01);
        chk(4'd0, 8'h58, "R8 live again");

        // R2: counter holds while stopped
        stop_clock();
        chk(4'd9, 8'h00, "R2 stopped");
        ticks(2 * TPS);
        chk(4'd0, 8'h58, "R2 no advance when stopped");

        // R5: full day carry, weekday 6 -> 0
        roll_day(8'h14, 8'h07, 8'h23, 8'h20, 8'h15, 8'h07, 8'h23, 8'h20, "R5 day carry");
        chk(4'd2, 8'h00, "R5 hour wrap"); chk(4'd1, 8'h00, "R5 min wrap");
        chk(4'd7, 8'h00, "R5 wday wrap");

        // R6: month lengths and leap years
        roll_day(8'h28, 8'h02, 8'h23, 8'h20, 8'h01, 8'h03, 8'h23, 8'h20, "R6 feb common");
        roll_day(8'h28, 8'h02, 8'h12, 8'h20, 8'h29, 8'h02, 8'h12, 8'h20, "R6 feb leap");
        roll_day(8'h30, 8'h04, 8'h23, 8'h20, 8'h01, 8'h05, 8'h23, 8'h20, "R6 30-day");
        roll_day(8'h30, 8'h05, 8'h23, 8'h20, 8'h31, 8'h05, 8'h23, 8'h20, "R6 31-day");

        // R7: year carries
        roll_day(8'h31, 8'h12, 8'h41, 8'h20, 8'h01, 8'h01, 8'h42, 8'h20, "R7 new year");
        roll_day(8'h31, 8'h12, 8'h99, 8'h20, 8'h01, 8'h01, 8'h00, 8'h21, "R7 century");

        // R9: direction and encoding
        comp_case(8'h10, 8'h05, 8'h83, 8'h01, 8'h01, 8'h05, TPS - 1, "R9 add shortens");
        ticks(3 * (TPS - 1));
        chk(4'd0, 8'h04, "R9 four seconds spent");
        ticks(TPS - 1);
        chk(4'd0, 8'h04, "R9 normal after spent");
        ticks(1);
        chk(4'd0, 8'h05, "R9 normal after spent");
        comp_case(8'h10, 8'h05, 8'h00, 8'h01, 8'h01, 8'h05, TPS + 1, "R9 subtract lengthens");
        comp_case(8'h10, 8'h05, 8'h81, 8'h01, 8'h01, 8'h05, TPS, "R9 value 1 none");

        // R11: enable clear
        comp_case(8'h10, 8'h05, 8'h83, 8'h01, 8'h01, 8'h01, TPS, "R11 disabled");

        // R10: level selection and summing
        comp_case(8'h10, 8'h05, 8'h01, 8'h83, 8'h01, 8'h05, TPS, "R10 daily not hour 23");
        comp_case(8'h23, 8'h05, 8'h01, 8'h83, 8'h01, 8'h05, TPS - 1, "R10 daily hour 23");
        comp_case(8'h23, 8'h15, 8'h01, 8'h01, 8'h83, 8'h05, TPS, "R10 monthly mid-month");
        comp_case(8'h23, 8'h31, 8'h01, 8'h01, 8'h83, 8'h05, TPS - 1, "R10 monthly last day");
        comp_case(8'h23, 8'h05, 8'h83, 8'h03, 8'h01, 8'h05, TPS, "R10 sum cancels");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule